// File: doc/BRIEF.md
# Display Command Decoder and Configuration Registers

This block sits behind the serial receiver of a monochrome dot-matrix display controller. It receives the bytes that the receiver has already marked as commands, one per cycle with a valid strobe. It decodes opcodes with no, one or two argument bytes and keeps the resulting configuration in registers: the addressing mode, the column window, the page window, the contrast level, display on/off, and forced all-pixels-on.

Direct pointer loads are sent on to the address pointer block as one-cycle load pulses that carry a value. They come from window start addresses, page-select opcodes and the split low/high column nibble opcodes. Opcodes the block does not implement, such as scrolling, remap and multiplex settings, take no argument bytes and are dropped.

Each accepted byte takes effect at the clock edge that samples it. Register outputs and load pulses are valid from that edge until the next edge.

Top module: `disp_cmd_decoder`

## Requirements
- R1: After synchronous reset, the outputs hold these values: addressing mode 2 (page), column window 0 to 127, page window 0 to 7, contrast 7Fh, display off, entire-on clear, and both load pulses low. The remembered column value is 0.
- R2: Opcode 20h takes one argument byte. Argument bits [1:0] set the addressing mode: 00 horizontal, 01 vertical, 10 page. The value 11 leaves the mode unchanged.
- R3: Opcode 21h takes two argument bytes, the column start and then the column end, each masked to 7 bits. The start byte also raises col_load for one cycle, with col_value equal to the start. The end byte raises no load.
- R4: Opcode 22h takes two argument bytes, the page start and then the page end, each masked to 3 bits. The start byte also raises page_load for one cycle, with page_value equal to the start.
- R5: Opcodes B0h to B7h raise page_load for one cycle, with page_value equal to opcode bits [2:0].
- R6: Opcodes 00h to 0Fh raise col_load with the low four bits of the last column value this block loaded, replaced by opcode bits [3:0]. Opcodes 10h to 1Fh replace the upper three bits of that value with opcode bits [2:0].
- R7: Opcode 81h takes one argument byte, which is loaded whole into the contrast register.
- R8: AEh clears display_on and AFh sets it. A4h clears entire_on and A5h sets it.
- R9: An argument byte is never decoded as an opcode, whatever its value.
- R10: Any other opcode takes no argument bytes and changes no output. The byte after it is decoded as an opcode.
- R11: Cycles with cmd_valid low change nothing. The argument bytes of one command may be separated by idle cycles.
- R12: col_load and page_load are never high in the same cycle. Each is high only in the cycle after a byte was accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_byte | input | 8 | Command or argument byte |
| cmd_valid | input | 1 | cmd_byte is valid this cycle |
| addr_mode | output | 2 | 0 horizontal, 1 vertical, 2 page |
| col_start | output | 7 | Column window start |
| col_end | output | 7 | Column window end |
| page_start | output | 3 | Page window start |
| page_end | output | 3 | Page window end |
| contrast | output | 8 | Contrast level |
| display_on | output | 1 | Display enabled |
| entire_on | output | 1 | All pixels forced on |
| col_load | output | 1 | One-cycle column pointer load |
| col_value | output | 7 | Column pointer load value |
| page_load | output | 1 | One-cycle page pointer load |
| page_value | output | 3 | Page pointer load value |

## Verification
The bench sends argument bytes that look like opcodes, for example AFh after 81h. A decoder that lost track of its argument count would switch the display on instead of setting the contrast. Sending the reserved mode value 11 would show a design that stores it, and an unknown opcode followed by a real one would show a design that wrongly swallows the next byte as an argument. The nibble opcodes are checked after a window load, because a design that did not remember the last column value, or did not mask the high nibble to three bits, would put out the wrong combined column.

// File: rtl/disp_cmd_pkg.sv
package disp_cmd_pkg;

    typedef enum logic [1:0] {
        MODE_HORIZ = 2'b00,
        MODE_VERT  = 2'b01,
        MODE_PAGE  = 2'b10
    } addr_mode_e;

    typedef enum logic [3:0] {
        EV_NONE,
        EV_MODE,
        EV_COL_START,
        EV_COL_END,
        EV_PAGE_START,
        EV_PAGE_END,
        EV_PAGE_PTR,
        EV_COL_LO,
        EV_COL_HI,
        EV_CONTRAST,
        EV_DISP_OFF,
        EV_DISP_ON,
        EV_NORMAL,
        EV_ALL_ON
    } evt_kind_e;

    typedef struct packed {
        logic      valid;
        evt_kind_e kind;
        logic [7:0] arg;
    } cmd_evt_t;

    typedef enum logic [1:0] {
        PS_OPCODE,
        PS_ARG1,
        PS_ARG2
    } parse_state_e;

    localparam logic [7:0] OP_MODE     = 8'h20;
    localparam logic [7:0] OP_COLWIN   = 8'h21;
    localparam logic [7:0] OP_PAGEWIN  = 8'h22;
    localparam logic [7:0] OP_CONTRAST = 8'h81;
    localparam logic [7:0] OP_NORMAL   = 8'hA4;
    localparam logic [7:0] OP_ALL_ON   = 8'hA5;
    localparam logic [7:0] OP_DISP_OFF = 8'hAE;
    localparam logic [7:0] OP_DISP_ON  = 8'hAF;

    // Number of argument bytes that follow an opcode.
    function automatic logic [1:0] arg_count(input logic [7:0] op);
        case (op)
            OP_MODE, OP_CONTRAST:  arg_count = 2'd1;
            OP_COLWIN, OP_PAGEWIN: arg_count = 2'd2;
            default:               arg_count = 2'd0;
        endcase
    endfunction

    // Event for an opcode without arguments.
    function automatic evt_kind_e classify_single(input logic [7:0] op);
        if (op[7:4] == 4'h0)
            classify_single = EV_COL_LO;
        else if (op[7:4] == 4'h1)
            classify_single = EV_COL_HI;
        else if (op[7:3] == 5'b10110)
            classify_single = EV_PAGE_PTR;
        else begin
            case (op)
                OP_NORMAL:   classify_single = EV_NORMAL;
                OP_ALL_ON:   classify_single = EV_ALL_ON;
                OP_DISP_OFF: classify_single = EV_DISP_OFF;
                OP_DISP_ON:  classify_single = EV_DISP_ON;
                default:     classify_single = EV_NONE;
            endcase
        end
    endfunction

endpackage

// File: rtl/disp_cmd_parser.sv
module disp_cmd_parser
    import disp_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] byte_in,
    input  logic       byte_valid,
    output cmd_evt_t   evt
);

    parse_state_e state_q, state_d;
    logic [7:0]   opcode_q;

    always_comb begin
        state_d   = state_q;
        evt.valid = 1'b0;
        evt.kind  = EV_NONE;
        evt.arg   = byte_in;
        if (byte_valid) begin
            case (state_q)
                PS_OPCODE: begin
                    if (arg_count(byte_in) == 2'd0) begin
                        evt.valid = 1'b1;
                        evt.kind  = classify_single(byte_in);
                    end else begin
                        state_d = PS_ARG1;
                    end
                end
                PS_ARG1: begin
                    evt.valid = 1'b1;
                    case (opcode_q)
                        OP_MODE:    evt.kind = EV_MODE;
                        OP_COLWIN:  evt.kind = EV_COL_START;
                        OP_PAGEWIN: evt.kind = EV_PAGE_START;
                        default:    evt.kind = EV_CONTRAST;
                    endcase
                    state_d = (arg_count(opcode_q) == 2'd2) ? PS_ARG2 : PS_OPCODE;
                end
                PS_ARG2: begin
                    evt.valid = 1'b1;
                    evt.kind  = (opcode_q == OP_COLWIN) ? EV_COL_END : EV_PAGE_END;
                    state_d   = PS_OPCODE;
                end
                default: state_d = PS_OPCODE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= PS_OPCODE;
            opcode_q <= 8'h00;
        end else begin
            state_q <= state_d;
            if (byte_valid && state_q == PS_OPCODE)
                opcode_q <= byte_in;
        end
    end

    AST_ARG2_AFTER_ARG1: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_ARG1 && byte_valid && arg_count(opcode_q) == 2'd2) |=> (state_q == PS_ARG2)); // R9
    AST_IDLE_HOLDS_STATE: assert property (@(posedge clk) disable iff (rst)
        !byte_valid |=> $stable(state_q)); // R11

endmodule

// File: rtl/disp_cfg_regs.sv
module disp_cfg_regs
    import disp_cmd_pkg::*;
#(
    parameter int COL_W  = 7,
    parameter int PAGE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_evt_t          evt,
    output addr_mode_e        mode,
    output logic [COL_W-1:0]  col_start,
    output logic [COL_W-1:0]  col_end,
    output logic [PAGE_W-1:0] page_start,
    output logic [PAGE_W-1:0] page_end,
    output logic [7:0]        contrast,
    output logic              display_on,
    output logic              entire_on,
    output logic              col_load,
    output logic [COL_W-1:0]  col_value,
    output logic              page_load,
    output logic [PAGE_W-1:0] page_value
);

    localparam int HI_W = COL_W - 4;
    localparam logic [COL_W-1:0]  COL_MAX  = {COL_W{1'b1}};
    localparam logic [PAGE_W-1:0] PAGE_MAX = {PAGE_W{1'b1}};

    logic [COL_W-1:0] col_shadow;
    logic [COL_W-1:0] nib_lo_val, nib_hi_val;

    assign nib_lo_val = {col_shadow[COL_W-1:4], evt.arg[3:0]};
    assign nib_hi_val = {evt.arg[HI_W-1:0], col_shadow[3:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            mode       <= MODE_PAGE;
            col_start  <= '0;
            col_end    <= COL_MAX;
            page_start <= '0;
            page_end   <= PAGE_MAX;
            contrast   <= 8'h7F;
            display_on <= 1'b0;
            entire_on  <= 1'b0;
            col_load   <= 1'b0;
            col_value  <= '0;
            page_load  <= 1'b0;
            page_value <= '0;
            col_shadow <= '0;
        end else begin
            col_load  <= 1'b0;
            page_load <= 1'b0;
            if (evt.valid) begin
                case (evt.kind)
                    EV_MODE:
                        if (evt.arg[1:0] != 2'b11)
                            mode <= addr_mode_e'(evt.arg[1:0]);
                    EV_COL_START: begin
                        col_start  <= evt.arg[COL_W-1:0];
                        col_load   <= 1'b1;
                        col_value  <= evt.arg[COL_W-1:0];
                        col_shadow <= evt.arg[COL_W-1:0];
                    end
                    EV_COL_END:    col_end <= evt.arg[COL_W-1:0];
                    EV_PAGE_START: begin
                        page_start <= evt.arg[PAGE_W-1:0];
                        page_load  <= 1'b1;
                        page_value <= evt.arg[PAGE_W-1:0];
                    end
                    EV_PAGE_END:   page_end <= evt.arg[PAGE_W-1:0];
                    EV_PAGE_PTR: begin
                        page_load  <= 1'b1;
                        page_value <= evt.arg[PAGE_W-1:0];
                    end
                    EV_COL_LO: begin
                        col_load   <= 1'b1;
                        col_value  <= nib_lo_val;
                        col_shadow <= nib_lo_val;
                    end
                    EV_COL_HI: begin
                        col_load   <= 1'b1;
                        col_value  <= nib_hi_val;
                        col_shadow <= nib_hi_val;
                    end
                    EV_CONTRAST:   contrast   <= evt.arg;
                    EV_DISP_OFF:   display_on <= 1'b0;
                    EV_DISP_ON:    display_on <= 1'b1;
                    EV_NORMAL:     entire_on  <= 1'b0;
                    EV_ALL_ON:     entire_on  <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        mode != addr_mode_e'(2'b11)); // R2
    AST_ONE_LOAD: assert property (@(posedge clk) disable iff (rst)
        $onehot0({col_load, page_load})); // R12
    AST_LOAD_NEEDS_EVT: assert property (@(posedge clk) disable iff (rst)
        !evt.valid |=> !col_load && !page_load); // R12
    AST_IDLE_CFG_STABLE: assert property (@(posedge clk) disable iff (rst)
        !evt.valid |=> $stable(contrast) && $stable(display_on) && $stable(mode)); // R11

endmodule

// File: rtl/disp_cmd_decoder.sv
module disp_cmd_decoder
    import disp_cmd_pkg::*;
#(
    parameter int COL_W  = 7,
    parameter int PAGE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        cmd_byte,
    input  logic              cmd_valid,
    output logic [1:0]        addr_mode,
    output logic [COL_W-1:0]  col_start,
    output logic [COL_W-1:0]  col_end,
    output logic [PAGE_W-1:0] page_start,
    output logic [PAGE_W-1:0] page_end,
    output logic [7:0]        contrast,
    output logic              display_on,
    output logic              entire_on,
    output logic              col_load,
    output logic [COL_W-1:0]  col_value,
    output logic              page_load,
    output logic [PAGE_W-1:0] page_value
);

    cmd_evt_t   evt;
    addr_mode_e mode;

    disp_cmd_parser u_parser (
        .clk        (clk),
        .rst        (rst),
        .byte_in    (cmd_byte),
        .byte_valid (cmd_valid),
        .evt        (evt)
    );

    disp_cfg_regs #(.COL_W(COL_W), .PAGE_W(PAGE_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .mode       (mode),
        .col_start  (col_start),
        .col_end    (col_end),
        .page_start (page_start),
        .page_end   (page_end),
        .contrast   (contrast),
        .display_on (display_on),
        .entire_on  (entire_on),
        .col_load   (col_load),
        .col_value  (col_value),
        .page_load  (page_load),
        .page_value (page_value)
    );

    assign addr_mode = mode;

endmodule

// File: tb/tb_disp_cmd_decoder.sv
module tb_disp_cmd_decoder;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] cmd_byte = 8'h00;
    logic       cmd_valid = 1'b0;
    logic [1:0] addr_mode;
    logic [6:0] col_start, col_end, col_value;
    logic [2:0] page_start, page_end, page_value;
    logic [7:0] contrast;
    logic       display_on, entire_on, col_load, page_load;

    int checks = 0;
    int errors = 0;
    logic       cl_seen, pl_seen;
    logic [6:0] cv_seen;
    logic [2:0] pv_seen;

    always #4 clk = ~clk;

    disp_cmd_decoder dut (
        .clk(clk), .rst(rst), .cmd_byte(cmd_byte), .cmd_valid(cmd_valid),
        .addr_mode(addr_mode), .col_start(col_start), .col_end(col_end),
        .page_start(page_start), .page_end(page_end), .contrast(contrast),
        .display_on(display_on), .entire_on(entire_on), .col_load(col_load),
        .col_value(col_value), .page_load(page_load), .page_value(page_value)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive one byte for one cycle; record load pulses in the following cycle.
    task automatic send(input logic [7:0] b);
        @(negedge clk);
        cmd_byte  = b;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        cl_seen = col_load;
        pl_seen = page_load;
        cv_seen = col_value;
        pv_seen = page_value;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 mode", addr_mode, 2);
        check("R1 col_start", col_start, 0);
        check("R1 col_end", col_end, 127);
        check("R1 page_start", page_start, 0);
        check("R1 page_end", page_end, 7);
        check("R1 contrast", contrast, 8'h7F);
        check("R1 display_on", display_on, 0);
        check("R1 entire_on", entire_on, 0);
        check("R1 loads", {col_load, page_load}, 0);
    endtask

    task automatic t_mode;
        send(8'h20); send(8'h00); check("R2 horiz", addr_mode, 0);
        send(8'h20); idle(3); send(8'h01); check("R2 R11 vert gap", addr_mode, 1);
        send(8'h20); send(8'h03); check("R2 reserved ignored", addr_mode, 1);
        send(8'h20); send(8'hFE); check("R2 page", addr_mode, 2);
    endtask

    task automatic t_col_window;
        send(8'h21); send(8'h85);
        check("R3 start load", cl_seen, 1);
        check("R3 start value", cv_seen, 7'h05);
        check("R12 no page load", pl_seen, 0);
        send(8'hFF);
        check("R3 end no load", cl_seen, 0);
        check("R3 col_start", col_start, 7'h05);
        check("R3 col_end", col_end, 7'h7F);
    endtask

    task automatic t_page_window;
        send(8'h22); send(8'h0A);
        check("R4 start load", pl_seen, 1);
        check("R4 start value", pv_seen, 2);
        send(8'h06);
        check("R4 end no load", pl_seen, 0);
        check("R4 page_start", page_start, 2);
        check("R4 page_end", page_end, 6);
    endtask

    task automatic t_page_ptr;
        send(8'hB5);
        check("R5 load", pl_seen, 1);
        check("R5 value", pv_seen, 5);
        check("R12 no col load", cl_seen, 0);
        check("R5 window untouched", page_start, 2);
    endtask

    task automatic t_nibbles;
        send(8'h1A);
        check("R6 hi load", cl_seen, 1);
        check("R6 hi value", cv_seen, 7'h25);
        send(8'h03);
        check("R6 lo value", cv_seen, 7'h23);
        send(8'h0F);
        check("R6 lo again", cv_seen, 7'h2F);
    endtask

    task automatic t_contrast;
        send(8'h81); send(8'h3C);
        check("R7 contrast", contrast, 8'h3C);
        send(8'h81); send(8'hAF);
        check("R9 arg as data", contrast, 8'hAF);
        check("R9 display untouched", display_on, 0);
        send(8'h21); send(8'hB3); send(8'h22);
        check("R9 end arg", col_end, 7'h22);
        check("R9 no page load", pl_seen, 0);
    endtask

    task automatic t_display;
        send(8'hAF); check("R8 on", display_on, 1);
        send(8'hA5); check("R8 entire", entire_on, 1);
        send(8'hA4); check("R8 normal", entire_on, 0);
        send(8'hAE); check("R8 off", display_on, 0);
    endtask

    task automatic t_unknown;
        send(8'hE3);
        check("R10 no load", {cl_seen, pl_seen}, 0);
        check("R10 contrast kept", contrast, 8'hAF);
        send(8'hAF);
        check("R10 next is opcode", display_on, 1);
        send(8'hD3); send(8'h20); send(8'h00);
        check("R10 mode after unknown", addr_mode, 0);
    endtask

    task automatic t_idle;
        @(negedge clk);
        cmd_byte = 8'hAE;
        cmd_valid = 1'b0;
        idle(4);
        check("R11 idle display", display_on, 1);
        check("R11 idle loads", {col_load, page_load}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_mode();
        t_col_window();
        t_page_window();
        t_page_ptr();
        t_nibbles();
        t_contrast();
        t_display();
        t_unknown();
        t_idle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule